// File: doc/BRIEF.md
# Timestamp-Gated Transmit Sample Unpacker

This block sits between a transmit sample FIFO and a digital-to-analogue converter that consumes one complex sample every two clocks. Each 32-bit FIFO word carries one complex sample: the in-phase value in the lower half and the quadrature value in the upper half, each a 12-bit two's-complement number in a 16-bit field. The block pulls one word every second clock, splits it and presents signed I and Q values with a one-cycle valid strobe.

A burst does not start on its own. Software hands the block a 64-bit start time with a valid pulse; the block then compares a free-running sample counter against it and begins streaming the first clock after the counter is at or beyond that time, so a time already in the past starts at once. If the FIFO runs dry at a due read slot, a zero sample goes out and a sticky underrun flag is raised. An end-of-burst pulse returns the block to waiting for the next start time.

The controller has three states. `UTX_IDLE` waits for a start time; taking one (transition *arm*) moves to `UTX_ARMED`. `UTX_ARMED` goes to `UTX_RUN` when the counter reaches the start time (transition *launch*) or back to `UTX_IDLE` on end-of-burst (transition *cancel*). `UTX_RUN` returns to `UTX_IDLE` on end-of-burst (transition *finish*).

Top module: `utx_unpacker`

## Requirements
- R1: While reset is held and right after it, `fifo_rd`, `tx_valid` and `underrun` are 0 and `tx_i`, `tx_q` are 0.
- R2: No word is read while waiting; when the counter first equals the start time in `UTX_ARMED`, the first `fifo_rd` comes in the next cycle, i.e. with the counter at start time plus one.
- R3: A start time at or below the current counter starts the burst immediately: `fifo_rd` is high two cycles after the cycle in which the start-time valid pulse is taken.
- R4: `tx_i` is bits [11:0] and `tx_q` is bits [27:16] of the word read, as 12-bit two's-complement values; bits [15:12] and [31:28] have no effect.
- R5: While streaming, read slots fall on alternate cycles starting with the first `UTX_RUN` cycle; `tx_valid` is high in the cycle after each slot and never in two adjacent cycles.
- R6: At a slot with the FIFO empty no read is made, `tx_valid` is high the next cycle with `tx_i` = `tx_q` = 0, and `underrun` becomes 1; `underrun` stays 1 until the next start time is taken, which clears it.
- R7: End-of-burst in `UTX_RUN` or `UTX_ARMED` returns to `UTX_IDLE`; it suppresses any read and any underrun in the same cycle, and no further word is read until a new start time.
- R8: A start-time valid pulse outside `UTX_IDLE` is ignored; the stream in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rdata | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop the head word this cycle |
| start_ts | input | 64 | Burst start time |
| start_ts_valid | input | 1 | Start time offered this cycle |
| sample_count | input | 64 | Free-running sample counter |
| burst_end | input | 1 | End the current burst |
| tx_i | output | 12 | Signed in-phase sample |
| tx_q | output | 12 | Signed quadrature sample |
| tx_valid | output | 1 | Sample on `tx_i`/`tx_q` is new this cycle |
| underrun | output | 1 | Sticky: a read slot found the FIFO empty |

## Verification
The two functions that can meet in one cycle are the underrun response and end-of-burst: a read slot with an empty FIFO may coincide with an end-of-burst pulse. The bench provokes this by draining a burst down to its last word, locating the next slot from the parity of `tx_valid`, and pulsing `burst_end` in exactly that slot. It judges end-of-burst the winner when the following cycle shows `tx_valid` low and `underrun` still at the 0 it was cleared to when the burst was armed.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        UTX_IDLE  = 2'd0,
        UTX_ARMED = 2'd1,
        UTX_RUN   = 2'd2
    } utx_state_e;

endpackage

// File: rtl/utx_ts_gate.sv
module utx_ts_gate #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ts_in,
    input  logic [CNT_W-1:0] count,
    output logic             reached
);
    logic [CNT_W-1:0] ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (load) begin
            ts_q <= ts_in;
        end
    end

    // unsigned compare: a start time already passed releases at once
    assign reached = (count >= ts_q);

    assert_ts_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ts_q));
endmodule

// File: rtl/utx_slot_pacer.sv
module utx_slot_pacer (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (!run) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign slot = run & ~phase_q;

    assert_slot_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> !slot);
endmodule

// File: rtl/utx_word_split.sv
module utx_word_split #(
    parameter int WORD_W   = 32,
    parameter int FIELD_W  = 16,
    parameter int SAMPLE_W = 12
) (
    input  logic [WORD_W-1:0]   word,
    output logic [SAMPLE_W-1:0] re,
    output logic [SAMPLE_W-1:0] im
);
    localparam int LANES = WORD_W / FIELD_W;

    logic [SAMPLE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*FIELD_W +: SAMPLE_W];
    end

    assign re = lane[0];
    assign im = lane[1];

    initial begin
        assert_lane_fit_R4: assert (LANES >= 2 && SAMPLE_W <= FIELD_W);
    end
endmodule

// File: rtl/utx_unpacker.sv
module utx_unpacker #(
    parameter int CNT_W    = 64,
    parameter int WORD_W   = 32,
    parameter int FIELD_W  = 16,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   fifo_rdata,
    input  logic                fifo_empty,
    output logic                fifo_rd,
    input  logic [CNT_W-1:0]    start_ts,
    input  logic                start_ts_valid,
    input  logic [CNT_W-1:0]    sample_count,
    input  logic                burst_end,
    output logic [SAMPLE_W-1:0] tx_i,
    output logic [SAMPLE_W-1:0] tx_q,
    output logic                tx_valid,
    output logic                underrun
);
    import utx_pkg::*;

    utx_state_e state_q, state_d;

    logic ts_load;
    logic reached;
    logic run;
    logic slot;
    logic gap;
    logic [SAMPLE_W-1:0] split_re, split_im;

    assign ts_load = (state_q == UTX_IDLE) && start_ts_valid;
    assign run     = (state_q == UTX_RUN);

    utx_ts_gate #(.CNT_W(CNT_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ts_load),
        .ts_in   (start_ts),
        .count   (sample_count),
        .reached (reached)
    );

    utx_slot_pacer u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .slot  (slot)
    );

    utx_word_split #(
        .WORD_W   (WORD_W),
        .FIELD_W  (FIELD_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_split (
        .word (fifo_rdata),
        .re   (split_re),
        .im   (split_im)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UTX_IDLE: begin
                if (start_ts_valid) state_d = UTX_ARMED;      // arm
            end
            UTX_ARMED: begin
                if (burst_end)    state_d = UTX_IDLE;         // cancel
                else if (reached) state_d = UTX_RUN;          // launch
            end
            UTX_RUN: begin
                if (burst_end) state_d = UTX_IDLE;            // finish
            end
            default: state_d = UTX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UTX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // end-of-burst outranks both read and underrun in a slot
    assign fifo_rd = slot && !fifo_empty && !burst_end;
    assign gap     = slot &&  fifo_empty && !burst_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_i     <= '0;
            tx_q     <= '0;
            tx_valid <= 1'b0;
            underrun <= 1'b0;
        end else begin
            tx_valid <= fifo_rd || gap;
            if (fifo_rd) begin
                tx_i <= split_re;
                tx_q <= split_im;
            end else if (gap) begin
                tx_i <= '0;
                tx_q <= '0;
            end
            if (ts_load) begin
                underrun <= 1'b0;
            end else if (gap) begin
                underrun <= 1'b1;
            end
        end
    end

    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);
    assert_valid_after_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> tx_valid);
    assert_valid_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);
    assert_underrun_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (tx_valid && tx_i == '0 && tx_q == '0));
    assert_end_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> !fifo_rd);
    assert_wait_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != UTX_RUN) |-> !fifo_rd);
endmodule

// File: tb/tb_utx_unpacker.sv
`timescale 1ns/1ps
module tb_utx_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_rdata;
    logic        fifo_empty;
    logic        fifo_rd;
    logic [63:0] start_ts = '0;
    logic        start_ts_valid = 1'b0;
    logic [63:0] cnt;
    logic        burst_end = 1'b0;
    logic [11:0] tx_i, tx_q;
    logic        tx_valid, underrun;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    utx_unpacker dut (
        .clk(clk), .rst_n(rst_n), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .start_ts(start_ts), .start_ts_valid(start_ts_valid),
        .sample_count(cnt), .burst_end(burst_end), .tx_i(tx_i), .tx_q(tx_q),
        .tx_valid(tx_valid), .underrun(underrun)
    );

    always @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 64'd1;
    end

    // show-ahead FIFO model
    logic [31:0] mem [32];
    logic [5:0]  wp = '0;
    logic [5:0]  rp = '0;
    assign fifo_rdata = mem[rp[4:0]];
    assign fifo_empty = (wp == rp);
    always @(posedge clk) if (fifo_rd) rp <= rp + 6'd1;

    localparam logic [31:0] VEC_W [8] = '{
        32'h0000_0000, 32'h0001_07FF, 32'h0800_0800, 32'hFFFF_FFFF,
        32'hF123_F456, 32'h0ABC_0555, 32'h7001_8FFE, 32'h0321_0CDE };
    localparam logic [11:0] EXP_I [8] = '{
        12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'h456, 12'h555, 12'hFFE, 12'hCDE };
    localparam logic [11:0] EXP_Q [8] = '{
        12'h000, 12'h001, 12'h800, 12'hFFF, 12'h123, 12'hABC, 12'h001, 12'h321 };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        mem[wp[4:0]] = w;
        wp = wp + 6'd1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] ts_val;
        bit seen;
        // R1 reset state
        repeat (4) @(negedge clk);
        chk(!fifo_rd && !tx_valid && !underrun, "R1 reset controls", {fifo_rd, tx_valid, underrun}, 0);
        chk(tx_i == 0 && tx_q == 0, "R1 reset data", {tx_i, tx_q}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fifo_rd && !tx_valid && !underrun, "R1 after reset", {fifo_rd, tx_valid, underrun}, 0);

        // table-driven burst: R2 gating, R4 split, R5 pacing
        for (int k = 0; k < 8; k++) push(VEC_W[k]);
        @(negedge clk);
        ts_val = cnt + 64'd10;
        start_ts = ts_val;
        start_ts_valid = 1'b1;
        @(negedge clk);
        start_ts_valid = 1'b0;
        seen = 0;
        for (int w = 0; w < 40 && !seen; w++) begin
            if (fifo_rd) seen = 1;
            else @(negedge clk);
        end
        chk(seen && cnt == ts_val + 64'd1, "R2 first read time", cnt, ts_val + 64'd1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(tx_valid == 1'b1, "R5 valid after slot", tx_valid, 1);
            chk(tx_i == EXP_I[k], "R4 I field", tx_i, EXP_I[k]);
            chk(tx_q == EXP_Q[k], "R4 Q field", tx_q, EXP_Q[k]);
            chk(!fifo_rd, "R5 no read off-slot", fifo_rd, 0);
            @(negedge clk);
            chk(!tx_valid, "R5 valid gap", tx_valid, 0);
            chk(fifo_rd == (k < 7), "R5 next slot read", fifo_rd, (k < 7));
        end
        // R6 underrun at empty slot
        @(negedge clk);
        chk(tx_valid && tx_i == 0 && tx_q == 0, "R6 zero sample", {tx_valid, tx_i, tx_q}, 64'h1_000_000);
        chk(underrun, "R6 underrun set", underrun, 1);
        // R8 start time offered mid-burst is ignored
        push(32'h0002_0003);
        start_ts = 64'hFFFF_FFFF_FFFF_FFFF;
        start_ts_valid = 1'b1;
        @(negedge clk);
        start_ts_valid = 1'b0;
        chk(fifo_rd, "R8 stream continues", fifo_rd, 1);
        @(negedge clk);
        chk(tx_valid && tx_i == 12'h003 && tx_q == 12'h002, "R8 sample after restart", {tx_valid, tx_i, tx_q}, 64'h1_003_002);
        chk(underrun, "R6 underrun sticky", underrun, 1);
        // R7 finish, then stays idle with data present
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
        push(32'h0005_0006);
        seen = 0;
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            if (fifo_rd || tx_valid) seen = 1;
        end
        chk(!seen, "R7 idle after end", seen, 0);

        // R3 stale start time, R6 clear, coincidence of underrun and end
        start_ts = 64'd0;
        start_ts_valid = 1'b1;
        @(negedge clk);
        start_ts_valid = 1'b0;
        chk(!fifo_rd && !underrun, "R6 clear on arm", {fifo_rd, underrun}, 0);
        @(negedge clk);
        chk(fifo_rd, "R3 immediate start", fifo_rd, 1);
        @(negedge clk);
        chk(tx_valid && tx_i == 12'h006 && tx_q == 12'h005, "R3 first sample", {tx_valid, tx_i, tx_q}, 64'h1_006_005);
        @(negedge clk);
        burst_end = 1'b1;   // empty-FIFO slot
        @(negedge clk);
        burst_end = 1'b0;
        chk(!tx_valid, "R7 end beats underrun valid", tx_valid, 0);
        chk(!underrun, "R7 end beats underrun flag", underrun, 0);

        // R7 cancel while armed
        push(32'h0009_0008);
        start_ts = cnt + 64'd6;
        start_ts_valid = 1'b1;
        @(negedge clk);
        start_ts_valid = 1'b0;
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
        seen = 0;
        for (int w = 0; w < 20; w++) begin
            @(negedge clk);
            if (fifo_rd || tx_valid) seen = 1;
        end
        chk(!seen, "R7 cancel while armed", seen, 0);

        finish_run();
    end
endmodule